// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status Bank

This block watches a bank of general-purpose input pins and turns activity on them into sticky per-pin status bits and one combined interrupt line. Each pin is set up as level or edge triggered, with a polarity. Two separate enable bits per pin decide its behaviour. The latch enable decides whether a detected condition may set the pin's status bit. The report enable decides whether a set status bit reaches the combined interrupt line.

Software configures the bank and services it through a small register port. It writes configuration words that hold one bit per pin, reads the status word, and clears individual status bits by writing ones to an acknowledge address. Because latching and reporting are gated separately, a handler can stop a level source from latching again before it acknowledges it. In that case the acknowledge sticks even while the pin is still active. Edge sources can leave the latch enable alone.

Register map (3-bit address; the data word has one bit per pin, bit n = pin n):
address 0 = trigger mode (0 level, 1 edge); address 1 = polarity (1 active-high or rising, 0 active-low or falling); address 2 = latch enable; address 3 = report enable; address 4 = status (read only); address 5 = acknowledge (write only, reads 0). Addresses 6 and 7 read 0.

Top module: `gpio_irq_bank`

## Requirements
- R1: When a pin's latch enable (address 2) is 0, that pin's status bit (address 4) is never set, whatever the pin does.
- R2: A pin's report enable (address 3) has no effect on whether its status bit latches.
- R3: `irqOut` is 1 exactly when some pin has both its status bit and its report enable set.
- R4: In level mode with latch enable 1, an acknowledge issued while the pin is still at its active level leaves the status bit set. The status bit stays set after the pin goes inactive, until it is acknowledged.
- R5: In level mode with latch enable 0, an acknowledge clears the status bit, and the bit stays clear while the pin remains active.
- R6: In edge mode with latch enable 1, each active edge (rising if polarity is 1, falling if 0) sets the status bit once. An acknowledge clears it, and it does not set again while the pin holds its level. The opposite edge sets nothing.
- R7: Setting a pin's latch enable to 1 while an edge-mode pin already rests at its post-edge level does not set the status bit.
- R8: If an acknowledge for a pin and a new detected event for that pin fall on the same clock edge, the status bit ends up set.
- R9: An acknowledge write clears only the status bits written as 1. Bits written as 0 are untouched. Reading the acknowledge address returns 0.
- R10: After reset all configuration registers and status read 0 and `irqOut` is 0. Configuration writes read back at their addresses.
- R11: Pin inputs pass through two synchroniser flops. A change on a pin, applied before clock edge 1, is visible in status after clock edge 3 and not after edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Raw asynchronous pin levels |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | NUM_PINS | Write data, one bit per pin |
| regRdData | output | NUM_PINS | Combinational read data for `regAddr` |
| irqOut | output | 1 | Combined interrupt line |

## Verification
The assertions assume that `regWrEn` is a clean single-cycle strobe with a stable address and data around the sampling edge. They also assume that `pinIn` reaches the first synchroniser flop as an ordinary level, so `syncd` and the previous-sample register differ only when the pin really moved. The stimulus changes pins and register inputs only on falling clock edges. It holds each pin level for several cycles, so that every edge and every acknowledge lands on a known rising edge. The collision case places the acknowledge on exactly the third rising edge after the pin change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_POL    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LATCH  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_REPORT = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_ACK    = 3'd5;

  // Strobes from the register decoder to the datapath.
  typedef struct packed {
    logic wrMode;
    logic wrPol;
    logic wrLatch;
    logic wrReport;
    logic ackPulse;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PINS-1:0] modeCfg,
  input  logic [NUM_PINS-1:0] polCfg,
  input  logic [NUM_PINS-1:0] latchEn,
  input  logic [NUM_PINS-1:0] reportEn,
  input  logic [NUM_PINS-1:0] status,
  output ctrlStrobe_t         strobe,
  output logic [NUM_PINS-1:0] regRdData
);
  always_comb begin
    strobe          = '0;
    strobe.wrMode   = regWrEn && (regAddr == ADDR_MODE);
    strobe.wrPol    = regWrEn && (regAddr == ADDR_POL);
    strobe.wrLatch  = regWrEn && (regAddr == ADDR_LATCH);
    strobe.wrReport = regWrEn && (regAddr == ADDR_REPORT);
    strobe.ackPulse = regWrEn && (regAddr == ADDR_ACK);
  end

  always_comb begin
    case (regAddr)
      ADDR_MODE:   regRdData = modeCfg;
      ADDR_POL:    regRdData = polCfg;
      ADDR_LATCH:  regRdData = latchEn;
      ADDR_REPORT: regRdData = reportEn;
      ADDR_STATUS: regRdData = status;
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  ctrlStrobe_t         strobe,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] modeCfg,
  output logic [NUM_PINS-1:0] polCfg,
  output logic [NUM_PINS-1:0] latchEn,
  output logic [NUM_PINS-1:0] reportEn,
  output logic [NUM_PINS-1:0] status
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];
  logic [NUM_PINS-1:0] syncd;
  logic [NUM_PINS-1:0] prevSample;
  logic [NUM_PINS-1:0] levelHit;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] evt;
  logic [NUM_PINS-1:0] ackHit;

  // Synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end
  assign syncd = syncChain[LAST_STAGE];

  // Previous sample always tracks, independent of any enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSample <= '0;
    else       prevSample <= syncd;
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCfg  <= '0;
      polCfg   <= '0;
      latchEn  <= '0;
      reportEn <= '0;
    end else begin
      if (strobe.wrMode)   modeCfg  <= wrData;
      if (strobe.wrPol)    polCfg   <= wrData;
      if (strobe.wrLatch)  latchEn  <= wrData;
      if (strobe.wrReport) reportEn <= wrData;
    end
  end

  // Per-pin detection
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign levelHit[i] = polCfg[i] ? syncd[i] : ~syncd[i];
    assign edgeHit[i]  = polCfg[i] ? (syncd[i] & ~prevSample[i])
                                   : (~syncd[i] & prevSample[i]);
    assign evt[i]      = latchEn[i] & (modeCfg[i] ? edgeHit[i] : levelHit[i]);
    assign ackHit[i]   = strobe.ackPulse & wrData[i];

    // R1
    latch_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(status[i]) |-> $past(latchEn[i]));
    // R9
    ack_only_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(status[i]) |-> $past(strobe.ackPulse && wrData[i]));
    // R7
    edge_real_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(status[i]) && $past(modeCfg[i])) |-> ($past(syncd[i]) != $past(prevSample[i])));
    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      evt[i] |=> status[i]);
    // R5
    no_relatch_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!latchEn[i] && !status[i]) |=> !status[i]);
  end

  // Sticky status: a new event outranks an acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= evt | (status & ~ackHit);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  output logic                irqOut
);
  ctrlStrobe_t         strobe;
  logic [NUM_PINS-1:0] modeCfg;
  logic [NUM_PINS-1:0] polCfg;
  logic [NUM_PINS-1:0] latchEn;
  logic [NUM_PINS-1:0] reportEn;
  logic [NUM_PINS-1:0] status;

  gpio_irq_ctrl #(.NUM_PINS(NUM_PINS)) ctrl_i (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .modeCfg  (modeCfg),
    .polCfg   (polCfg),
    .latchEn  (latchEn),
    .reportEn (reportEn),
    .status   (status),
    .strobe   (strobe),
    .regRdData(regRdData)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .strobe  (strobe),
    .wrData  (regWrData),
    .modeCfg (modeCfg),
    .polCfg  (polCfg),
    .latchEn (latchEn),
    .reportEn(reportEn),
    .status  (status)
  );

  assign irqOut = |(status & reportEn);

  // R3
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|status));
  // R3
  irq_needs_report_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|reportEn) |-> !irqOut);
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb_top;
  localparam int N = 8;
  localparam logic [2:0] A_MODE = 3'd0, A_POL = 3'd1, A_LATCH = 3'd2,
                         A_REPORT = 3'd3, A_STATUS = 3'd4, A_ACK = 3'd5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] pinIn = '0;
  logic         regWrEn = 1'b0;
  logic [2:0]   regAddr = '0;
  logic [N-1:0] regWrData = '0;
  logic [N-1:0] regRdData;
  logic         irqOut;

  int vecCount = 0;
  int missCount = 0;
  logic [N-1:0] modeSh = '0, polSh = '0, latchSh = '0, reportSh = '0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_irq_bank #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [N-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [N-1:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic statusBit(input int p, output logic b);
    logic [N-1:0] v;
    readReg(A_STATUS, v);
    b = v[p];
  endtask

  task automatic setCfg(input int p, input logic m, input logic pl, input logic le, input logic re);
    modeSh[p] = m; polSh[p] = pl; latchSh[p] = le; reportSh[p] = re;
    writeReg(A_MODE, modeSh);
    writeReg(A_POL, polSh);
    writeReg(A_LATCH, latchSh);
    writeReg(A_REPORT, reportSh);
  endtask

  task automatic testReset();
    logic [N-1:0] v;
    for (int a = 0; a < 6; a++) begin
      readReg(3'(a), v);
      checkVal("R10 reset register", v, '0);
    end
    checkVal("R10 reset irq", irqOut, 0);
    setCfg(0, 1'b0, 1'b1, 1'b1, 1'b0);
    readReg(A_POL, v);   checkVal("R10 pol readback", v, 8'h01);
    readReg(A_LATCH, v); checkVal("R10 latch readback", v, 8'h01);
  endtask

  task automatic testLevelRelatch();
    logic b;
    pinIn[0] = 1'b1; idle(4);
    statusBit(0, b); checkVal("R2 latches with report off", b, 1);
    checkVal("R3 irq off when report off", irqOut, 0);
    setCfg(0, 1'b0, 1'b1, 1'b1, 1'b1); #1;
    checkVal("R3 irq on", irqOut, 1);
    writeReg(A_ACK, 8'h01); idle(2);
    statusBit(0, b); checkVal("R4 relatch after ack", b, 1);
    pinIn[0] = 1'b0; idle(4);
    statusBit(0, b); checkVal("R4 sticky after release", b, 1);
    writeReg(A_ACK, 8'h01); #1;
    statusBit(0, b); checkVal("R4 ack after release clears", b, 0);
    checkVal("R3 irq clears", irqOut, 0);
  endtask

  task automatic testLevelNoRelatch();
    logic b;
    setCfg(1, 1'b0, 1'b1, 1'b1, 1'b0);
    pinIn[1] = 1'b1; idle(4);
    statusBit(1, b); checkVal("R5 initial latch", b, 1);
    setCfg(1, 1'b0, 1'b1, 1'b0, 1'b0);
    writeReg(A_ACK, 8'h02); idle(4);
    statusBit(1, b); checkVal("R5 stays clear while active", b, 0);
    setCfg(5, 1'b0, 1'b1, 1'b0, 1'b1);
    pinIn[5] = 1'b1; idle(4);
    statusBit(5, b); checkVal("R1 latch disabled", b, 0);
    checkVal("R1 irq stays low", irqOut, 0);
    pinIn[1] = 1'b0; pinIn[5] = 1'b0; idle(3);
  endtask

  task automatic testEdge();
    logic b;
    setCfg(2, 1'b1, 1'b1, 1'b1, 1'b0);
    pinIn[2] = 1'b1; idle(4);
    statusBit(2, b); checkVal("R6 rising edge latch", b, 1);
    writeReg(A_ACK, 8'h04); idle(3);
    statusBit(2, b); checkVal("R6 no relatch while high", b, 0);
    pinIn[2] = 1'b0; idle(4);
    statusBit(2, b); checkVal("R6 falling ignored", b, 0);
    setCfg(3, 1'b1, 1'b0, 1'b1, 1'b0);
    idle(3);
    pinIn[3] = 1'b1; idle(4);
    statusBit(3, b); checkVal("R6 rising ignored at pol 0", b, 0);
    pinIn[3] = 1'b0; idle(4);
    statusBit(3, b); checkVal("R6 falling edge latch", b, 1);
    writeReg(A_ACK, 8'h08); #1;
    statusBit(3, b); checkVal("R6 ack clears", b, 0);
  endtask

  task automatic testLatchToggle();
    logic b;
    setCfg(4, 1'b1, 1'b1, 1'b0, 1'b0);
    pinIn[4] = 1'b1; idle(4);
    setCfg(4, 1'b1, 1'b1, 1'b1, 1'b0); idle(4);
    statusBit(4, b); checkVal("R7 enable no spurious edge", b, 0);
    setCfg(4, 1'b1, 1'b1, 1'b0, 1'b0);
    setCfg(4, 1'b1, 1'b1, 1'b1, 1'b0); idle(3);
    statusBit(4, b); checkVal("R7 retoggle no spurious edge", b, 0);
    pinIn[4] = 1'b0; idle(3);
  endtask

  task automatic testCollision();
    logic b;
    pinIn[2] = 1'b1; idle(2);
    statusBit(2, b); checkVal("R11 not set after edge 2", b, 0);
    idle(1);
    statusBit(2, b); checkVal("R11 set after edge 3", b, 1);
    pinIn[2] = 1'b0; idle(4);
    statusBit(2, b); checkVal("R8 pre-state set", b, 1);
    pinIn[2] = 1'b1; idle(2);
    writeReg(A_ACK, 8'h04);
    statusBit(2, b); checkVal("R8 event wins over ack", b, 1);
    writeReg(A_ACK, 8'h04); #1;
    statusBit(2, b); checkVal("R8 later ack clears", b, 0);
    pinIn[2] = 1'b0; idle(3);
  endtask

  task automatic testAckMask();
    logic [N-1:0] v;
    setCfg(6, 1'b0, 1'b1, 1'b1, 1'b1);
    setCfg(7, 1'b0, 1'b1, 1'b1, 1'b1);
    pinIn[7:6] = 2'b11; idle(4);
    pinIn[7:6] = 2'b00; idle(4);
    readReg(A_STATUS, v); checkVal("R9 both latched", v[7:6], 2'b11);
    writeReg(A_ACK, 8'h40); #1;
    readReg(A_STATUS, v); checkVal("R9 masked ack", v[7:6], 2'b10);
    checkVal("R3 irq from remaining pin", irqOut, 1);
    readReg(A_ACK, v); checkVal("R9 ack reads zero", v, '0);
    setCfg(7, 1'b0, 1'b1, 1'b1, 1'b0); #1;
    readReg(A_STATUS, v); checkVal("R2 report off keeps status", v[7], 1);
    checkVal("R3 irq off with report off", irqOut, 0);
    writeReg(A_ACK, 8'h80); #1;
    readReg(A_STATUS, v); checkVal("R9 final clear", v, '0);
  endtask

  initial begin
    #(20 * 150000);
    missCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLevelRelatch();
    testLevelNoRelatch();
    testEdge();
    testLatchToggle();
    testCollision();
    testAckMask();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule